// File: doc/BRIEF.md
# Crystal Oscillator Bias Trim Controller

This block owns the bias trim word of a crystal oscillator and keeps it at the lowest setting that still sustains oscillation, plus a safety margin. Two comparator flags come from the analog side. `comp_lo` high means the bias is enough to sustain oscillation. `comp_hi` high means the bias is larger than needed. The controller drives the trim, enables the oscillator, waits a fixed settle time after each trim change, and then samples the flags.

Three one-shot commands start the work:

- **Search** runs a successive-approximation pass over the trim bits.
- **Switch** runs a step-by-step correction loop. At its end it hands the clock over to the crystal by raising `xtal_sel`.
- **Check** applies one correction step based on the flags as they are now. It is meant to be issued now and then by upper layers once the crystal is running.

A shadow trim register holds the result between commands. When the first switch command arrives, the shadow is loaded from `preset_trim`. If that value is all ones (an erased value), a search runs first and the switch loop follows it.

Top module: `xtc_bias_trim_ctrl`

## Requirements
- R1: After reset, `trim_out` is 0 and `osc_en`, `xtal_sel`, `busy` and `done` are all 0.
- R2: A search sets `osc_en` to 1, clears `xtal_sel`, and starts from trim 0. It visits the bits from the most significant down. For each bit it sets the bit, settles, and clears the bit again if `comp_lo` reads 1. After the last bit, if the final sample had `comp_lo` at 0, the trim is raised by 1. The safety offset of R4 is then applied.
- R3: Every trim value applied during a search or switch is held for SETTLE_CYC cycles before the flags are sampled. A switch that needs one sample and no final rewrite raises `done` SETTLE_CYC+1 cycles after the command edge. A switch that also needs the final rewrite takes 2·SETTLE_CYC+1 cycles.
- R4: Applying the offset to a value v gives v+OFFSET when v < MAX−OFFSET, and MAX otherwise. MAX is all ones (15 by default) and OFFSET is 2. The trim never wraps past MAX.
- R5: Each switch-loop sample works in two steps. If `comp_lo` is 0, the trim rises by 1, saturating at MAX. Then, if `comp_hi` is 1, the trim falls by 1, but only when it is above MIN_TRIM (2).
- R6: The switch loop stops when `comp_hi` is 0 and `comp_lo` is 1, or when the trim is no longer strictly between MIN_TRIM and MAX. If the last sample had `comp_lo` at 0, or the trim is below OFFSET, the offset is applied. If the offset was applied, or any decrement happened during the loop, the trim is settled once more. Only then does `xtal_sel` go to 1.
- R7: A check takes one step from the current flags, with no settle wait. If `comp_hi` is 1, it subtracts 1. If `comp_lo` is 0, it adds 1 and then applies the offset. The result is floored at OFFSET. A check leaves `xtal_sel` unchanged.
- R8: A switch on an uninitialised shadow loads `preset_trim`. If `preset_trim` is all ones, a full search runs first instead. A switch on an initialised shadow starts from the current trim.
- R9: `busy` is high from the cycle after an accepted command until the end of the `done` pulse. `done` lasts exactly one cycle. Commands that arrive while `busy` is high are ignored.
- R10: When commands arrive together, search wins over switch, and switch wins over check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_search | input | 1 | Start a successive-approximation search |
| cmd_switch | input | 1 | Start the correction loop and crystal hand-over |
| cmd_check | input | 1 | Apply one periodic correction step |
| preset_trim | input | TRIM_W | Stored trim loaded on the first switch; all ones means erased |
| comp_hi | input | 1 | Comparator flag: bias above need |
| comp_lo | input | 1 | Comparator flag: bias sufficient |
| trim_out | output | TRIM_W | Applied bias trim (shadow register) |
| osc_en | output | 1 | Crystal oscillator enable |
| xtal_sel | output | 1 | Select the crystal as clock source |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach from the ports is a trim below the minimum while the switch loop runs. Checks floor their results and the loop never decrements below MIN_TRIM, so that state only comes from a preset load on an uninitialised shadow. The bench therefore resets the block again before driving a switch with a preset of 1. The erased-preset chain and the ignored mid-operation commands also need fresh resets or precise timing. The bench models the comparator as two trim thresholds, so each scenario is set just by choosing where those thresholds sit.

// File: rtl/xtc_pkg.sv
package xtc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SR_SET,
      ST_SR_WAIT,
      ST_SR_END,
      ST_SW_APPLY,
      ST_SW_WAIT,
      ST_SW_FINAL,
      ST_DONE
   } xtc_state_e;

   // saturating safety margin: below the knee add the margin, else pin at top
   function automatic int sat_off(input int v, input int maxv, input int off);
      return (v < maxv - off) ? v + off : maxv;
   endfunction

endpackage

// File: rtl/xtc_settle_timer.sv
module xtc_settle_timer #(
   parameter int SETTLE_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic running,
   output logic fire
);
   localparam int CNT_W = $clog2(SETTLE_CYC + 1);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end

   if (SETTLE_CYC == 1) begin : g_flop
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) f_q <= 1'b0;
         else        f_q <= start;
      end
      assign running = f_q;
      assign fire    = f_q;
   end else begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cnt_q <= '0;
         else if (start)        cnt_q <= CNT_W'(SETTLE_CYC);
         else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end
      assign running = (cnt_q != '0);
      assign fire    = (cnt_q == CNT_W'(1));

      a_r3_fire_after_full_count: assert property (@(posedge clk) disable iff (!rst_n)
         start |=> (cnt_q == CNT_W'(SETTLE_CYC)));
   end

endmodule

// File: rtl/xtc_trim_step.sv
module xtc_trim_step #(
   parameter int TRIM_W   = 4,
   parameter int OFFSET   = 2,
   parameter int MIN_TRIM = 2
) (
   input  logic [TRIM_W-1:0] trim,
   input  logic              hi,
   input  logic              lo,
   output logic [TRIM_W-1:0] sw_trim,
   output logic              sw_dec,
   output logic              sw_more,
   output logic              sw_fin_add,
   output logic [TRIM_W-1:0] sw_fin_trim,
   output logic [TRIM_W-1:0] chk_trim
);
   localparam int MAXV = (1 << TRIM_W) - 1;

   int t1, t2, c;

   always_comb begin
      // switch-loop step: raise on missing bias, then lower on excess bias
      t1 = lo ? int'(trim) : ((int'(trim) < MAXV) ? int'(trim) + 1 : int'(trim));
      sw_dec = hi && (t1 > MIN_TRIM);
      t2 = sw_dec ? t1 - 1 : t1;
      sw_more = (hi || !lo) && (t2 < MAXV) && (t2 > MIN_TRIM);
      sw_trim = TRIM_W'(t2);
      sw_fin_add = !lo || (t2 < OFFSET);
      sw_fin_trim = TRIM_W'(xtc_pkg::sat_off(t2, MAXV, OFFSET));

      // periodic single step, floored at the margin
      c = int'(trim) - (hi ? 1 : 0);
      if (!lo) c = xtc_pkg::sat_off(c + 1, MAXV, OFFSET);
      if (c < OFFSET) c = OFFSET;
      chk_trim = TRIM_W'(c);
   end

   always_comb begin
      a_r7_check_floor: assert (int'(chk_trim) >= OFFSET || trim === 'x);
   end

endmodule

// File: rtl/xtc_bias_trim_ctrl.sv
module xtc_bias_trim_ctrl #(
   parameter int TRIM_W     = 4,
   parameter int OFFSET     = 2,
   parameter int MIN_TRIM   = 2,
   parameter int SETTLE_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_search,
   input  logic              cmd_switch,
   input  logic              cmd_check,
   input  logic [TRIM_W-1:0] preset_trim,
   input  logic              comp_hi,
   input  logic              comp_lo,
   output logic [TRIM_W-1:0] trim_out,
   output logic              osc_en,
   output logic              xtal_sel,
   output logic              busy,
   output logic              done
);
   import xtc_pkg::*;

   localparam int MAXV = (1 << TRIM_W) - 1;
   localparam logic [TRIM_W-1:0] MSB_BIT = {1'b1, {(TRIM_W-1){1'b0}}};

   if (TRIM_W < 2 || TRIM_W > 16) begin : g_bad_width
      $error("TRIM_W out of range");
   end
   if (OFFSET < 1 || OFFSET >= MAXV) begin : g_bad_offset
      $error("OFFSET must lie inside the trim range");
   end
   if (MIN_TRIM < 0 || MIN_TRIM >= MAXV) begin : g_bad_min
      $error("MIN_TRIM must lie below the maximum trim");
   end

   xtc_state_e        state_q;
   logic [TRIM_W-1:0] trim_q, bit_q;
   logic              init_q, last_lo_q, chain_q, setlast_q, osc_en_q, sel_q;
   logic              tmr_start, tmr_run, tmr_fire;
   logic [TRIM_W-1:0] sw_trim, sw_fin_trim, chk_trim;
   logic              sw_dec, sw_more, sw_fin_add;

   xtc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(tmr_start),
      .running(tmr_run), .fire(tmr_fire)
   );

   xtc_trim_step #(.TRIM_W(TRIM_W), .OFFSET(OFFSET), .MIN_TRIM(MIN_TRIM)) u_step (
      .trim(trim_q), .hi(comp_hi), .lo(comp_lo),
      .sw_trim(sw_trim), .sw_dec(sw_dec), .sw_more(sw_more),
      .sw_fin_add(sw_fin_add), .sw_fin_trim(sw_fin_trim), .chk_trim(chk_trim)
   );

   always_comb begin
      tmr_start = (state_q == ST_SR_SET) || (state_q == ST_SW_APPLY) ||
                  (state_q == ST_SW_WAIT && tmr_fire && !sw_more &&
                   (sw_fin_add || setlast_q || sw_dec));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         trim_q    <= '0;
         bit_q     <= '0;
         init_q    <= 1'b0;
         last_lo_q <= 1'b0;
         chain_q   <= 1'b0;
         setlast_q <= 1'b0;
         osc_en_q  <= 1'b0;
         sel_q     <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_search) begin
                  trim_q   <= '0;
                  bit_q    <= MSB_BIT;
                  osc_en_q <= 1'b1;
                  sel_q    <= 1'b0;
                  chain_q  <= 1'b0;
                  state_q  <= ST_SR_SET;
               end else if (cmd_switch) begin
                  osc_en_q  <= 1'b1;
                  sel_q     <= 1'b0;
                  setlast_q <= 1'b0;
                  if (init_q) begin
                     state_q <= ST_SW_APPLY;
                  end else if (&preset_trim) begin
                     trim_q  <= '0;
                     bit_q   <= MSB_BIT;
                     chain_q <= 1'b1;
                     state_q <= ST_SR_SET;
                  end else begin
                     trim_q  <= preset_trim;
                     init_q  <= 1'b1;
                     state_q <= ST_SW_APPLY;
                  end
               end else if (cmd_check) begin
                  trim_q  <= chk_trim;
                  state_q <= ST_DONE;
               end
            end
            ST_SR_SET: begin
               trim_q  <= trim_q | bit_q;
               state_q <= ST_SR_WAIT;
            end
            ST_SR_WAIT: begin
               if (tmr_fire) begin
                  if (comp_lo) trim_q <= trim_q & ~bit_q;
                  last_lo_q <= comp_lo;
                  bit_q     <= bit_q >> 1;
                  state_q   <= bit_q[0] ? ST_SR_END : ST_SR_SET;
               end
            end
            ST_SR_END: begin
               trim_q <= TRIM_W'(sat_off(int'(trim_q) + (last_lo_q ? 0 : 1), MAXV, OFFSET));
               init_q <= 1'b1;
               if (chain_q) begin
                  chain_q   <= 1'b0;
                  setlast_q <= 1'b0;
                  state_q   <= ST_SW_APPLY;
               end else begin
                  state_q <= ST_DONE;
               end
            end
            ST_SW_APPLY: state_q <= ST_SW_WAIT;
            ST_SW_WAIT: begin
               if (tmr_fire) begin
                  setlast_q <= setlast_q | sw_dec;
                  if (sw_more) begin
                     trim_q  <= sw_trim;
                     state_q <= ST_SW_APPLY;
                  end else if (sw_fin_add) begin
                     trim_q  <= sw_fin_trim;
                     state_q <= ST_SW_FINAL;
                  end else if (setlast_q || sw_dec) begin
                     trim_q  <= sw_trim;
                     state_q <= ST_SW_FINAL;
                  end else begin
                     trim_q  <= sw_trim;
                     sel_q   <= 1'b1;
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_SW_FINAL: begin
               if (tmr_fire) begin
                  sel_q   <= 1'b1;
                  state_q <= ST_DONE;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign trim_out = trim_q;
   assign osc_en   = osc_en_q;
   assign xtal_sel = sel_q;
   assign busy     = (state_q != ST_IDLE);
   assign done     = (state_q == ST_DONE);

   // R3: trim may not move while a settle window is still open
   a_r3_trim_settles: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_run && !tmr_fire) |=> $stable(trim_q));
   // R9: completion is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6: hand-over coincides with completion
   a_r6_sel_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xtal_sel) |-> done);
   // R6: the crystal is never selected while disabled
   a_r6_sel_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
      xtal_sel |-> osc_en);
   // R9: no command is taken while an operation runs
   a_r9_busy_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

endmodule

// File: tb/xtc_bias_trim_ctrl_tb_top.sv
module xtc_bias_trim_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 8;
   localparam int NVEC       = 17;
   // {op[1:0], lo_th[4:0], hi_th[4:0], exp_trim[3:0], exp_sel}; op 1 search, 2 switch, 3 check
   localparam logic [16:0] VEC [NVEC] = '{
      {2'd2, 5'd5,  5'd7,  4'd6,  1'b1},
      {2'd3, 5'd5,  5'd6,  4'd5,  1'b1},
      {2'd3, 5'd7,  5'd15, 4'd8,  1'b1},
      {2'd2, 5'd3,  5'd6,  4'd5,  1'b1},
      {2'd2, 5'd9,  5'd14, 4'd9,  1'b1},
      {2'd2, 5'd16, 5'd16, 4'd15, 1'b1},
      {2'd2, 5'd0,  5'd0,  4'd2,  1'b1},
      {2'd3, 5'd0,  5'd0,  4'd2,  1'b1},
      {2'd1, 5'd12, 5'd16, 4'd14, 1'b0},
      {2'd3, 5'd16, 5'd16, 4'd15, 1'b0},
      {2'd1, 5'd16, 5'd16, 4'd15, 1'b0},
      {2'd1, 5'd14, 5'd16, 4'd15, 1'b0},
      {2'd1, 5'd13, 5'd16, 4'd14, 1'b0},
      {2'd1, 5'd0,  5'd16, 4'd2,  1'b0},
      {2'd1, 5'd5,  5'd16, 4'd6,  1'b0},
      {2'd1, 5'd4,  5'd16, 4'd6,  1'b0},
      {2'd2, 5'd0,  5'd16, 4'd6,  1'b1}
   };

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       cmd_search = 1'b0, cmd_switch = 1'b0, cmd_check = 1'b0;
   logic [3:0] preset_trim = 4'hF;
   logic [4:0] lo_th = 5'd0, hi_th = 5'd16;
   logic       comp_hi, comp_lo;
   logic [3:0] trim_out;
   logic       osc_en, xtal_sel, busy, done;
   int checks = 0, errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // comparator model: thresholds on the applied trim
   assign comp_lo = ({1'b0, trim_out} >= lo_th);
   assign comp_hi = ({1'b0, trim_out} >= hi_th);

   xtc_bias_trim_ctrl #(.SETTLE_CYC(SETTLE)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_search(cmd_search), .cmd_switch(cmd_switch),
      .cmd_check(cmd_check), .preset_trim(preset_trim), .comp_hi(comp_hi),
      .comp_lo(comp_lo), .trim_out(trim_out), .osc_en(osc_en), .xtal_sel(xtal_sel),
      .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // issue commands for one cycle, return edges until done is seen
   task automatic run_op(input bit s, input bit w, input bit c, output int cyc);
      @(negedge clk);
      cmd_search = s; cmd_switch = w; cmd_check = c;
      @(negedge clk);
      cmd_search = 0; cmd_switch = 0; cmd_check = 0;
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int cyc, ndone;
      do_reset();
      // R1 reset state
      check(trim_out == 0 && !osc_en && !xtal_sel && !busy && !done, "R1 reset",
            {trim_out, osc_en, xtal_sel, busy, done}, 0);

      // R8 erased preset: search (lo at 5 -> 4, +2 -> 6) then switch keeps 6
      preset_trim = 4'hF; lo_th = 5; hi_th = 12;
      run_op(0, 1, 0, cyc);
      check(trim_out == 6 && xtal_sel, "R8 erased preset search+switch", trim_out, 6);
      check(osc_en, "R2 oscillator enabled", osc_en, 1);

      for (int i = 0; i < NVEC; i++) begin
         logic [1:0] op;
         op = VEC[i][16:15];
         lo_th = VEC[i][14:10];
         hi_th = VEC[i][9:5];
         run_op(op == 1, op == 2, op == 3, cyc);
         if (op == 1)
            check(trim_out == VEC[i][4:1] && xtal_sel == VEC[i][0], "R2 R4 search", trim_out, VEC[i][4:1]);
         else if (op == 2)
            check(trim_out == VEC[i][4:1] && xtal_sel == VEC[i][0], "R5 R6 switch", trim_out, VEC[i][4:1]);
         else
            check(trim_out == VEC[i][4:1] && xtal_sel == VEC[i][0], "R7 R4 check", trim_out, VEC[i][4:1]);
         if (i == 0) check(cyc == SETTLE + 1, "R3 single-sample switch latency", cyc, SETTLE + 1);
      end

      // R6 trim below minimum via preset: 1 -> offset -> 3 with a final settle
      do_reset();
      preset_trim = 4'd1; lo_th = 0; hi_th = 16;
      run_op(0, 1, 0, cyc);
      check(trim_out == 3 && xtal_sel, "R6 below-offset trim corrected", trim_out, 3);
      check(cyc == 2 * SETTLE + 1, "R3 latency with final rewrite", cyc, 2 * SETTLE + 1);

      // R9 commands during busy are ignored; 3 climbs to 6 then stops
      lo_th = 6; hi_th = 16;
      @(negedge clk); cmd_switch = 1;
      @(negedge clk); cmd_switch = 0;
      repeat (5) @(negedge clk);
      check(busy, "R9 busy during loop", busy, 1);
      cmd_search = 1; cmd_check = 1;
      @(negedge clk); cmd_search = 0; cmd_check = 0;
      ndone = 0;
      for (int k = 0; k < 200 && !done; k++) @(negedge clk);
      while (done) begin ndone++; @(negedge clk); end
      check(trim_out == 6 && xtal_sel, "R9 mid-run commands ignored", trim_out, 6);
      check(ndone == 1, "R9 done pulse width", ndone, 1);
      check(!busy, "R9 busy released", busy, 0);

      // R10 search beats check: same trim, but search clears the select
      lo_th = 4; hi_th = 16;
      run_op(1, 0, 1, cyc);
      check(trim_out == 6 && !xtal_sel, "R10 search wins over check", {trim_out, xtal_sel}, 12);

      // R10 switch beats check: trim 6 ok, select set again
      lo_th = 0; hi_th = 16;
      run_op(0, 1, 1, cyc);
      check(xtal_sel && cyc == SETTLE + 1, "R10 switch wins over check", cyc, SETTLE + 1);

      // R8 valid preset is loaded directly
      do_reset();
      preset_trim = 4'd7; lo_th = 0; hi_th = 16;
      run_op(0, 1, 0, cyc);
      check(trim_out == 7 && xtal_sel, "R8 preset loaded", trim_out, 7);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule